// File: doc/BRIEF.md
# Memory Protection Region Checker

This block judges every bus access against eight programmable address regions. Each access is either permitted or flagged as a memory management fault. An access is described by its address, a privileged flag, a kind (data read, data write or instruction fetch) and a code for the current execution priority. The block also reports whether the fixed default memory map, rather than a programmed region, settled the outcome.

Software programs the block through a single write port. The port reaches four registers: a control word, a region number, and the base and attribute words of the region that the region number currently selects. Each region is a naturally aligned power-of-two window. It has an enable, a size, a permission code and an execute-never bit. When regions overlap, the one with the highest number decides. Control bits set three things: whether protection is active, whether privileged code falls back to the default map on a miss, and whether checking continues at the two highest (negative) priorities.

The decision is combinational from the registered configuration. A register write changes the decision from the next rising clock edge.

Top module: `mpu_region_checker`

## Requirements
- R1: With the control enable bit (control bit 0) at 0, every access gets the default-map result and `acc_default_map` is 1. The default map faults only instruction fetches (kind 2) whose address has bits [31:29] = 3'b111, and permits everything else.
- R2: With protection active, an unprivileged access that hits no enabled region and is not in the always-permitted areas faults, and `acc_default_map` is 0.
- R3: With protection active, a privileged access that hits no region gets the default-map result (`acc_default_map` = 1) when control bit 2 is 1, and faults when that bit is 0. With every region disabled and bit 2 set, only privileged accesses succeed.
- R4: While protection is active, reads and writes to the system control window (address bits [31:12] = 20'hE000E) and to the vector table (the first 1024 bytes) are permitted whatever the regions say. Instruction fetches from the system control window always fault.
- R5: For priority code 2'b01 (-1) or 2'b10 (-2), when control bit 1 is 0 the access is judged as if protection were off. When bit 1 is 1, checking stays active. Codes 2'b00 and 2'b11 are ordinary priorities.
- R6: The region number register (select 1) takes bits [7:0] of the write data. Values above 7 are ignored and leave the register unchanged. Base (select 2) and attribute (select 3) writes act on the selected region.
- R7: A base write with bit 4 (valid) set loads bits [3:0] into the region number and writes that region's base. If that field is above 7, the whole write is ignored.
- R8: A region with attribute bit 0 (enable) set covers the naturally aligned window of 2^(size+1) bytes, where size is attribute bits [5:1]. The base comes from base bits [31:5]. Size values below 4 act as 4, giving 32 bytes.
- R9: When several enabled regions match, the highest-numbered one decides the outcome.
- R10: Attribute bits [9:8] select the permission code: 0 no access, 1 privileged only, 2 privileged any plus unprivileged read-only (fetch counts as a read), 3 full access.
- R11: Attribute bit 12 (execute-never) makes instruction fetches that the region decides fault.
- R12: After reset, control, region number and all regions are zero, so the block acts as disabled. A configuration write changes the outputs only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 region number, 2 base, 3 attribute |
| cfg_wdata | input | 32 | Configuration write data |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_kind | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 treated as read |
| acc_prio | input | 2 | 2'b01 priority -1, 2'b10 priority -2, other codes ordinary |
| acc_fault | output | 1 | Memory management fault for the present access |
| acc_default_map | output | 1 | Decision came from the default memory map |

## Verification
A wrong region number or a region write that lands in the wrong slot is invisible until an access falls inside the affected window. The bench therefore probes addresses inside, at the edge of and just outside every programmed window, in the same cycle that follows each write. A corrupted control bit shows at once as a flipped fault or default-map flag on misses, at negative priorities and for privileged fallbacks. A wrong overlap winner shows only on addresses covered by two regions, so those addresses are swept with every privilege and access kind.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RNUM = 2'd1,
    SEL_BASE = 2'd2,
    SEL_ATTR = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic       xn;
    logic [1:0] ap;
    logic [4:0] size;
    logic       en;
  } region_attr_t;

  localparam logic [1:0] AP_NONE      = 2'd0;
  localparam logic [1:0] AP_PRIV      = 2'd1;
  localparam logic [1:0] AP_UNPRIV_RO = 2'd2;
  localparam logic [1:0] AP_FULL      = 2'd3;

  function automatic logic ap_permits(input logic [1:0] ap, input logic priv,
                                      input logic is_write);
    logic ok;
    case (ap)
      AP_NONE:      ok = 1'b0;
      AP_PRIV:      ok = priv;
      AP_UNPRIV_RO: ok = priv | ~is_write;
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cfg_we,
  input  logic [1:0]                            cfg_sel,
  input  logic [DATA_W-1:0]                     cfg_wdata,
  output logic                                  ctrl_en,
  output logic                                  ctrl_hfnmi,
  output logic                                  ctrl_privdef,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    base_q,
  output region_attr_t [NUM_REGIONS-1:0]        attr_q
);

  localparam int IDX_W = $clog2(NUM_REGIONS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGIONS);
  localparam logic [3:0] NREG4 = 4'(NUM_REGIONS);

  cfg_sel_e         sel;
  logic [IDX_W-1:0] rnum_q;
  logic             rnum_wr_ok;
  logic             base_valid;
  logic [3:0]       base_field;
  logic             base_wr_ok;
  logic [IDX_W-1:0] base_target;
  logic             attr_wr;
  region_attr_t     attr_new;

  assign sel         = cfg_sel_e'(cfg_sel);
  assign rnum_wr_ok  = cfg_we && (sel == SEL_RNUM) && (cfg_wdata[7:0] < NREG8);
  assign base_valid  = cfg_wdata[4];
  assign base_field  = cfg_wdata[3:0];
  assign base_wr_ok  = cfg_we && (sel == SEL_BASE) && (!base_valid || (base_field < NREG4));
  assign base_target = base_valid ? base_field[IDX_W-1:0] : rnum_q;
  assign attr_wr     = cfg_we && (sel == SEL_ATTR);

  always_comb begin
    attr_new.en   = cfg_wdata[0];
    attr_new.size = cfg_wdata[5:1];
    attr_new.ap   = cfg_wdata[9:8];
    attr_new.xn   = cfg_wdata[12];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en      <= 1'b0;
      ctrl_hfnmi   <= 1'b0;
      ctrl_privdef <= 1'b0;
      rnum_q       <= '0;
    end else begin
      if (cfg_we && (sel == SEL_CTRL)) begin
        ctrl_en      <= cfg_wdata[0];
        ctrl_hfnmi   <= cfg_wdata[1];
        ctrl_privdef <= cfg_wdata[2];
      end
      if (rnum_wr_ok)
        rnum_q <= cfg_wdata[IDX_W-1:0];
      else if (base_wr_ok && base_valid)
        rnum_q <= base_field[IDX_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end else begin
        if (base_wr_ok && (base_target == IDX_W'(i)))
          base_q[i] <= {cfg_wdata[ADDR_W-1:5], 5'b0};
        if (attr_wr && (rnum_q == IDX_W'(i)))
          attr_q[i] <= attr_new;
      end
    end
  end

  // R6: an out-of-range region number write leaves the selection alone
  assert_rnum_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_sel == 2'd1) && (cfg_wdata[7:0] >= NREG8)) |=> $stable(rnum_q));

  // R7: a legal valid base write moves the selection
  assert_valid_base_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_sel == 2'd2) && cfg_wdata[4] && (cfg_wdata[3:0] < NREG4))
    |=> (rnum_q == $past(cfg_wdata[IDX_W-1:0])));

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q,
  input  region_attr_t [NUM_REGIONS-1:0]     attr_q,
  output logic                               any_hit,
  output region_attr_t                       hit_attr
);

  localparam int IDX_W = $clog2(NUM_REGIONS);

  logic [NUM_REGIONS-1:0] hit_vec;
  logic [IDX_W-1:0]       hit_idx;

  function automatic logic [ADDR_W-1:0] win_mask(input logic [4:0] sz);
    logic [5:0]      sh;
    logic [ADDR_W:0] span;
    sh   = (sz < 5'd4) ? 6'd5 : ({1'b0, sz} + 6'd1);
    span = ((ADDR_W+1)'(1) << sh) - (ADDR_W+1)'(1);
    return ~span[ADDR_W-1:0];
  endfunction

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    assign hit_vec[i] = attr_q[i].en &&
                        (((addr ^ base_q[i]) & win_mask(attr_q[i].size)) == '0);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign any_hit  = |hit_vec;
  assign hit_attr = attr_q[hit_idx];

  // R9: the chosen region is the highest-numbered match
  assert_winner_R9: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> ((hit_vec >> hit_idx) == NUM_REGIONS'(1)));

endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
  import mpu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VTAB_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              ctrl_hfnmi,
  input  logic              ctrl_privdef,
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic [1:0]        kind,
  input  logic [1:0]        prio,
  input  logic              any_hit,
  input  region_attr_t      hit_attr,
  output logic              fault,
  output logic              use_default
);

  localparam logic [19:0] SCS_PAGE = 20'hE000E;

  logic is_fetch, is_write, prio_top, bypass;
  logic in_scs, in_vtab, sys_zone, dflt_fault, region_fault;

  assign is_fetch     = (kind == KIND_FETCH);
  assign is_write     = (kind == KIND_WRITE);
  assign prio_top     = (prio == 2'b01) || (prio == 2'b10);
  assign bypass       = !ctrl_en || (prio_top && !ctrl_hfnmi);
  assign in_scs       = (addr[ADDR_W-1 -: 20] == SCS_PAGE);
  assign in_vtab      = (addr[ADDR_W-1:VTAB_LOG2] == '0);
  assign sys_zone     = (addr[ADDR_W-1 -: 3] == 3'b111);
  assign dflt_fault   = is_fetch && sys_zone;
  assign region_fault = !ap_permits(hit_attr.ap, priv, is_write) || (is_fetch && hit_attr.xn);

  always_comb begin
    if (bypass || in_scs || in_vtab) begin
      fault       = dflt_fault;
      use_default = 1'b1;
    end else if (any_hit) begin
      fault       = region_fault;
      use_default = 1'b0;
    end else if (priv && ctrl_privdef) begin
      fault       = dflt_fault;
      use_default = 1'b1;
    end else begin
      fault       = 1'b1;
      use_default = 1'b0;
    end
  end

  assert_disabled_default_R1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !is_fetch) |-> (!fault && use_default));

  assert_unpriv_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !(prio_top && !ctrl_hfnmi) && !any_hit && !priv && !in_scs && !in_vtab)
    |-> fault);

  assert_scs_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (is_fetch && in_scs) |-> fault);

  assert_special_permit_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && (in_scs || in_vtab) && !is_fetch) |-> !fault);

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (prio_top && !ctrl_hfnmi) |-> use_default);

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int VTAB_LOG2   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_prio,
  output logic              acc_fault,
  output logic              acc_default_map
);

  logic                               ctrl_en, ctrl_hfnmi, ctrl_privdef;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
  region_attr_t [NUM_REGIONS-1:0]     attr_q;
  logic                               any_hit;
  region_attr_t                       hit_attr;

  mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_en(ctrl_en), .ctrl_hfnmi(ctrl_hfnmi), .ctrl_privdef(ctrl_privdef),
    .base_q(base_q), .attr_q(attr_q)
  );

  mpu_region_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .addr(acc_addr), .base_q(base_q), .attr_q(attr_q),
    .any_hit(any_hit), .hit_attr(hit_attr)
  );

  mpu_decide #(.ADDR_W(ADDR_W), .VTAB_LOG2(VTAB_LOG2)) u_decide (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_hfnmi(ctrl_hfnmi),
    .ctrl_privdef(ctrl_privdef), .addr(acc_addr), .priv(acc_priv), .kind(acc_kind),
    .prio(acc_prio), .any_hit(any_hit), .hit_attr(hit_attr),
    .fault(acc_fault), .use_default(acc_default_map)
  );

endmodule

// File: tb/mpu_region_checker_tb.sv
module mpu_region_checker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] acc_addr = 32'd0;
  logic        acc_priv = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic [1:0]  acc_prio = 2'd0;
  logic        acc_fault, acc_default_map;

  always #5 clk = ~clk;

  mpu_region_checker u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind), .acc_prio(acc_prio),
    .acc_fault(acc_fault), .acc_default_map(acc_default_map)
  );

  // behavioural reference state
  logic [31:0] m_base [8];
  int m_en [8], m_size [8], m_ap [8], m_xn [8];
  int m_enable, m_hf, m_pd, m_rnum;
  int n_cmp = 0, n_bad = 0;

  logic [31:0] probe [11] = '{32'h0000_0100, 32'h0001_0000, 32'h2000_0010, 32'h2000_0210,
                              32'h2000_1000, 32'h2000_101F, 32'h2000_1020, 32'h4000_0000,
                              32'hE000_ED00, 32'hE010_0000, 32'h0004_0000};

  task automatic model_reset();
    for (int r = 0; r < 8; r++) begin
      m_base[r] = 0; m_en[r] = 0; m_size[r] = 0; m_ap[r] = 0; m_xn[r] = 0;
    end
    m_enable = 0; m_hf = 0; m_pd = 0; m_rnum = 0;
  endtask

  task automatic model_write(input int sel, input logic [31:0] d);
    case (sel)
      0: begin m_enable = d[0]; m_hf = d[1]; m_pd = d[2]; end
      1: if (d[7:0] < 8) m_rnum = d[7:0];
      2: if (!(d[4] && d[3:0] >= 8)) begin
           if (d[4]) m_rnum = d[3:0];
           m_base[m_rnum] = d & 32'hFFFF_FFE0;
         end
      default: begin
        m_en[m_rnum] = d[0]; m_size[m_rnum] = d[5:1];
        m_ap[m_rnum] = d[9:8]; m_xn[m_rnum] = d[12];
      end
    endcase
  endtask

  task automatic expect_of(input logic [31:0] a, input logic p, input int k, input int pr,
                           output logic ef, output logic ed);
    logic df;
    logic ok;
    longint win;
    df = (k == 2) && (a[31:29] == 3'b111);
    if (!m_enable || ((pr == 1 || pr == 2) && !m_hf) || a[31:12] == 20'hE000E || a < 1024) begin
      ef = df; ed = 1; return;
    end
    for (int r = 7; r >= 0; r--) begin
      win = longint'(1) << ((m_size[r] < 4 ? 4 : m_size[r]) + 1);
      if (m_en[r] != 0 && (longint'(a) / win) == (longint'(m_base[r]) / win)) begin
        case (m_ap[r])
          0: ok = 0;
          1: ok = p;
          2: ok = p || (k != 1);
          default: ok = 1;
        endcase
        ef = !ok || (k == 2 && m_xn[r] != 0); ed = 0; return;
      end
    end
    if (p && m_pd) begin ef = df; ed = 1; return; end
    ef = 1; ed = 0;
  endtask

  task automatic compare(input string tag);
    logic ef, ed;
    expect_of(acc_addr, acc_priv, acc_kind, acc_prio, ef, ed);
    n_cmp++;
    if (acc_fault !== ef || acc_default_map !== ed) begin
      n_bad++;
      $display("FAIL %s addr=%h priv=%0d kind=%0d prio=%0d: fault/default %b%b expected %b%b",
               tag, acc_addr, acc_priv, acc_kind, acc_prio, acc_fault, acc_default_map, ef, ed);
    end
  endtask

  task automatic probe_one(input logic [31:0] a, input logic p, input int k, input int pr,
                           input string tag);
    @(negedge clk);
    acc_addr = a; acc_priv = p; acc_kind = 2'(k); acc_prio = 2'(pr);
    #1 compare(tag);
  endtask

  task automatic sweep(input int pr, input string tag);
    for (int i = 0; i < 11; i++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 3; k++)
          probe_one(probe[i], p[0], k, pr, tag);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = d;
    @(posedge clk);
    model_write(sel, d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    sweep(0, "R12");                                  // reset state acts disabled
    // program regions while still disabled
    wr(1, 32'd0);  wr(2, 32'h0000_0000); wr(3, 32'h0000_0323);         // R0 256KB full
    wr(2, 32'h2000_0011); wr(3, 32'h0000_1213);                        // R1 via valid, 1KB ro xn
    wr(2, 32'h2000_0212); wr(3, 32'h0000_0111);                        // R2 512B priv
    wr(2, 32'h2000_1013); wr(3, 32'h0000_0301);                        // R3 size0 -> 32B
    sweep(0, "R1");
    wr(0, 32'h1);
    sweep(0, "R10");
    probe_one(32'h2000_101F, 0, 1, 0, "R8");
    probe_one(32'h2000_1020, 0, 0, 0, "R8");
    probe_one(32'h2000_0210, 0, 0, 0, "R9");
    probe_one(32'h2000_0210, 1, 1, 0, "R9");
    probe_one(32'h2000_0010, 1, 2, 0, "R11");
    probe_one(32'h4000_0000, 0, 0, 0, "R2");
    probe_one(32'hE000_ED00, 0, 1, 0, "R4");
    probe_one(32'hE000_ED00, 1, 2, 0, "R4");
    probe_one(32'h0000_0100, 0, 1, 0, "R4");
    // R6: illegal region number ignored, attribute lands on region 3
    wr(1, 32'd9); wr(3, 32'h0000_0009);
    probe_one(32'h2000_1000, 1, 0, 0, "R6");
    // R7: valid base with region 12 ignored entirely
    wr(2, 32'h3000_001C); wr(3, 32'h0000_0301);
    probe_one(32'h2000_1000, 1, 0, 0, "R7");
    probe_one(32'h3000_0000, 1, 0, 0, "R7");
    // R5: negative priorities
    sweep(1, "R5");
    sweep(2, "R5");
    wr(0, 32'h3);
    sweep(1, "R5");
    probe_one(32'h4000_0000, 0, 0, 3, "R5");
    // R3: privileged fallback
    probe_one(32'h4000_0000, 1, 0, 0, "R3");
    wr(0, 32'h5);
    sweep(0, "R3");
    for (int r = 0; r < 8; r++) begin wr(1, r); wr(3, 32'h0); end
    sweep(0, "R3");
    // R12: write visible only after the edge
    @(negedge clk);
    acc_addr = 32'h4000_0000; acc_priv = 0; acc_kind = 0; acc_prio = 0;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h0;
    #1 compare("R12");
    @(posedge clk);
    model_write(0, 32'h0);
    @(negedge clk);
    cfg_we = 0;
    #1 compare("R12");
    finish_run();
  end

endmodule